// File: doc/BRIEF.md
# Security Level Access Controller

This block guards a programmable memory against a serial programming host. It keeps a one-byte protection level and, for every operation a command decoder asks about, answers in the same cycle whether that operation may run. When it refuses, it also supplies the one-character reply the decoder sends back to the host. The memory array, erase timing and command parsing live outside the block.

The level can only tighten. It moves from open, to write-protected, to fully locked. The only way back to open is a full-chip erase. That erase also puts the two boot configuration bytes (boot status and boot vector) back to their defaults. Both bytes are held here, because their write permission and their erase behaviour are part of the same policy.

The decision depends only on the request inputs and the current level, so a decoder can act on the answer in the cycle it asks. Register updates take effect at the next rising clock edge.

Top module: `sec_gate_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the level becomes FFh, the boot status byte becomes FFh and the boot vector byte becomes FCh. With `req_valid` low, `rsp_grant` and `rsp_deny` are 0 and `rsp_code` is 00h.
- R2: A level write (opcode 4) carries the new level in `req_data`. It is granted only if `req_data` is FEh or FCh and ranks strictly above the current level, with the ranking FFh < FEh < FCh. A granted write loads the level at the next edge. Any other level write is denied with code 'P' and leaves the level unchanged.
- R3: The opcodes are 0 memory read, 1 memory write, 2 config read, 3 config write, 4 level write, 5 block erase, 6 full erase, 7 blank check and 8 identification read. At level FFh every one of them is granted, except a level write that breaks R2.
- R4: At level FEh, memory write, config write and block erase are denied with 'P'. Memory read and config read are granted.
- R5: At level FCh, memory read and config read are denied with 'L'. Memory write, config write and block erase are denied with 'P'.
- R6: Full erase, blank check and identification read are granted at every level.
- R7: A granted full erase sets the level to FFh, boot status to FFh and boot vector to FCh at the next edge.
- R8: A granted config write loads `req_data` into boot status when `req_sel` is 0, or into boot vector when `req_sel` is 1, at the next edge. A denied config write changes neither byte.
- R9: Opcodes 9 to 15 are unknown and are denied with 'P' at every level. They change no register.
- R10: Exactly one of `rsp_grant` and `rsp_deny` is high in every cycle where `req_valid` is high, and it appears in that same cycle. `rsp_code` is 50h ('P') or 4Ch ('L') while `rsp_deny` is high, and 00h otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_op | input | 4 | Operation code (see R3, R9) |
| req_sel | input | 1 | Config write target: 0 boot status, 1 boot vector |
| req_data | input | 8 | New level or config byte value |
| rsp_grant | output | 1 | Operation may proceed |
| rsp_deny | output | 1 | Operation refused |
| rsp_code | output | 8 | Reply character on refusal, else 00h |
| sec_level | output | 8 | Current protection level |
| boot_status | output | 8 | Boot status byte |
| boot_vector | output | 8 | Boot vector byte |

## Verification
The assertions assume the request inputs are settled, with no X or Z, whenever `req_valid` is high. They also assume reset is held for at least one rising edge before the first request. The level-history properties are armed only one cycle after reset ends, so that every sampled past value is a post-reset value. The stimulus drives all request inputs on the falling edge to known values and holds reset for several edges at start-up. It walks the level upward only through real level writes, so the monotonic-level and erase-default properties see the same sequences a decoder would produce.

// File: rtl/secg_pkg.sv
package secg_pkg;

    localparam int BYTE_W = 8;
    localparam int OP_W   = 4;

    localparam logic [BYTE_W-1:0] LVL_OPEN   = 8'hFF;
    localparam logic [BYTE_W-1:0] LVL_WPROT  = 8'hFE;
    localparam logic [BYTE_W-1:0] LVL_LOCKED = 8'hFC;

    localparam logic [BYTE_W-1:0] BSTAT_DEFAULT = 8'hFF;
    localparam logic [BYTE_W-1:0] BVEC_DEFAULT  = 8'hFC;

    localparam logic [BYTE_W-1:0] CODE_NONE    = 8'h00;
    localparam logic [BYTE_W-1:0] CODE_WR_DENY = 8'h50;
    localparam logic [BYTE_W-1:0] CODE_RD_DENY = 8'h4C;

    typedef enum logic [OP_W-1:0] {
        OP_MEM_RD     = 4'd0,
        OP_MEM_WR     = 4'd1,
        OP_CFG_RD     = 4'd2,
        OP_CFG_WR     = 4'd3,
        OP_LVL_WR     = 4'd4,
        OP_BLK_ERASE  = 4'd5,
        OP_FULL_ERASE = 4'd6,
        OP_BLANK_CHK  = 4'd7,
        OP_ID_RD      = 4'd8
    } op_e;

    typedef struct packed {
        logic              grant;
        logic              deny;
        logic [BYTE_W-1:0] code;
    } verdict_t;

    typedef struct packed {
        logic              set_level;
        logic              wipe;
        logic              cfg_wr;
        logic              cfg_sel;
        logic [BYTE_W-1:0] value;
    } update_t;

    // Rank of a level encoding: 0 open, 1 write-protected, 2 locked, 3 invalid
    function automatic logic [1:0] lvl_rank(input logic [BYTE_W-1:0] v);
        case (v)
            LVL_OPEN:   return 2'd0;
            LVL_WPROT:  return 2'd1;
            LVL_LOCKED: return 2'd2;
            default:    return 2'd3;
        endcase
    endfunction

    function automatic logic is_level(input logic [BYTE_W-1:0] v);
        return lvl_rank(v) != 2'd3;
    endfunction

endpackage

// File: rtl/secg_policy.sv
module secg_policy
    import secg_pkg::*;
(
    input  logic              valid,
    input  logic [OP_W-1:0]   op,
    input  logic [BYTE_W-1:0] data,
    input  logic [BYTE_W-1:0] level,
    output verdict_t          verdict
);
    logic              allow;
    logic [BYTE_W-1:0] refuse_code;
    logic              is_open;
    logic              is_locked;
    logic              raise_ok;

    assign is_open   = (level == LVL_OPEN);
    assign is_locked = (level == LVL_LOCKED);
    assign raise_ok  = is_level(data) && (data != LVL_OPEN) &&
                       (lvl_rank(data) > lvl_rank(level));

    always_comb begin
        allow       = 1'b0;
        refuse_code = CODE_WR_DENY;
        case (op_e'(op))
            OP_MEM_RD, OP_CFG_RD: begin
                allow       = !is_locked;
                refuse_code = CODE_RD_DENY;
            end
            OP_MEM_WR, OP_CFG_WR, OP_BLK_ERASE: begin
                allow = is_open;
            end
            OP_LVL_WR: begin
                allow = raise_ok;
            end
            OP_FULL_ERASE, OP_BLANK_CHK, OP_ID_RD: begin
                allow = 1'b1;
            end
            default: begin
                allow = 1'b0;
            end
        endcase
    end

    always_comb begin
        verdict.grant = valid && allow;
        verdict.deny  = valid && !allow;
        verdict.code  = (valid && !allow) ? refuse_code : CODE_NONE;
    end

endmodule

// File: rtl/secg_update.sv
module secg_update
    import secg_pkg::*;
(
    input  logic              granted,
    input  logic [OP_W-1:0]   op,
    input  logic              sel,
    input  logic [BYTE_W-1:0] data,
    output update_t           upd
);
    always_comb begin
        upd.set_level = granted && (op == OP_LVL_WR);
        upd.wipe      = granted && (op == OP_FULL_ERASE);
        upd.cfg_wr    = granted && (op == OP_CFG_WR);
        upd.cfg_sel   = sel;
        upd.value     = data;
    end
endmodule

// File: rtl/secg_state.sv
module secg_state
    import secg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  update_t           upd,
    output logic [BYTE_W-1:0] level,
    output logic [BYTE_W-1:0] bstat,
    output logic [BYTE_W-1:0] bvec
);
    localparam int N_CFG = 2;

    logic [BYTE_W-1:0] cfg_q [N_CFG];
    logic              armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= LVL_OPEN;
        end else if (upd.wipe) begin
            level <= LVL_OPEN;
        end else if (upd.set_level) begin
            level <= upd.value;
        end
    end

    for (genvar i = 0; i < N_CFG; i++) begin : g_cfg
        localparam logic [BYTE_W-1:0] DEF = (i == 0) ? BSTAT_DEFAULT : BVEC_DEFAULT;
        always_ff @(posedge clk) begin
            if (rst || upd.wipe) begin
                cfg_q[i] <= DEF;
            end else if (upd.cfg_wr && (int'(upd.cfg_sel) == i)) begin
                cfg_q[i] <= upd.value;
            end
        end
    end

    assign bstat = cfg_q[0];
    assign bvec  = cfg_q[1];

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    AST_LEVEL_ENCODED: assert property (@(posedge clk) disable iff (rst || !armed)
        is_level(level)) else $error("level left the valid encodings"); // R2

    AST_LEVEL_ONLY_RISES: assert property (@(posedge clk) disable iff (rst || !armed)
        (level != $past(level)) && !$past(upd.wipe) |->
            lvl_rank(level) > lvl_rank($past(level))) else $error("level lowered"); // R2

    AST_WIPE_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        upd.wipe |=> (level == LVL_OPEN) && (bstat == BSTAT_DEFAULT) && (bvec == BVEC_DEFAULT))
        else $error("erase defaults missing"); // R7

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst || !armed)
        !$past(upd.cfg_wr) && !$past(upd.wipe) |-> $stable(bstat) && $stable(bvec))
        else $error("config byte changed without grant"); // R8

endmodule

// File: rtl/sec_gate_ctrl.sv
module sec_gate_ctrl
    import secg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [3:0]  req_op,
    input  logic        req_sel,
    input  logic [7:0]  req_data,
    output logic        rsp_grant,
    output logic        rsp_deny,
    output logic [7:0]  rsp_code,
    output logic [7:0]  sec_level,
    output logic [7:0]  boot_status,
    output logic [7:0]  boot_vector
);
    verdict_t verdict;
    update_t  upd;

    secg_policy u_policy (
        .valid   (req_valid),
        .op      (req_op),
        .data    (req_data),
        .level   (sec_level),
        .verdict (verdict)
    );

    secg_update u_update (
        .granted (verdict.grant),
        .op      (req_op),
        .sel     (req_sel),
        .data    (req_data),
        .upd     (upd)
    );

    secg_state u_state (
        .clk   (clk),
        .rst   (rst),
        .upd   (upd),
        .level (sec_level),
        .bstat (boot_status),
        .bvec  (boot_vector)
    );

    assign rsp_grant = verdict.grant;
    assign rsp_deny  = verdict.deny;
    assign rsp_code  = verdict.code;

    AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (rsp_grant ^ rsp_deny)) else $error("not exactly one answer"); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !rsp_grant && !rsp_deny && (rsp_code == CODE_NONE))
        else $error("answer without request"); // R1

    AST_DENY_CODE: assert property (@(posedge clk) disable iff (rst)
        rsp_deny |-> (rsp_code == CODE_WR_DENY) || (rsp_code == CODE_RD_DENY))
        else $error("bad refusal code"); // R10

    AST_LOCKED_NO_READ: assert property (@(posedge clk) disable iff (rst)
        req_valid && (sec_level == LVL_LOCKED) && (req_op == OP_MEM_RD) |->
            rsp_deny && (rsp_code == CODE_RD_DENY)) else $error("read leaked at lock"); // R5

    AST_ALWAYS_ERASE: assert property (@(posedge clk) disable iff (rst)
        req_valid && ((req_op == OP_FULL_ERASE) || (req_op == OP_BLANK_CHK) || (req_op == OP_ID_RD))
            |-> rsp_grant) else $error("always-allowed op refused"); // R6

    AST_UNKNOWN_OP: assert property (@(posedge clk) disable iff (rst)
        req_valid && (req_op > 4'd8) |-> rsp_deny && (rsp_code == CODE_WR_DENY))
        else $error("unknown op not refused"); // R9

endmodule

// File: tb/sim_sec_gate_ctrl.sv
`timescale 1ns/1ps
module sim_sec_gate_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [3:0] req_op = 4'd0;
    logic       req_sel = 1'b0;
    logic [7:0] req_data = 8'h00;
    logic       rsp_grant, rsp_deny;
    logic [7:0] rsp_code, sec_level, boot_status, boot_vector;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    sec_gate_ctrl u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_sel(req_sel), .req_data(req_data), .rsp_grant(rsp_grant),
        .rsp_deny(rsp_deny), .rsp_code(rsp_code), .sec_level(sec_level),
        .boot_status(boot_status), .boot_vector(boot_vector)
    );

    typedef struct packed {
        logic [3:0] op;
        logic       sel;
        logic [7:0] data;
        logic       eg;
        logic [7:0] ecode;
        logic [7:0] elvl;
        logic [7:0] ebsb;
        logic [7:0] esbv;
        logic [7:0] rq;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        '{4'd1, 1'b0, 8'h00, 1'b1, 8'h00, 8'hFF, 8'hFF, 8'hFC, 8'd3},  // R3 mem write open
        '{4'd3, 1'b0, 8'h55, 1'b1, 8'h00, 8'hFF, 8'h55, 8'hFC, 8'd8},  // R8 boot status
        '{4'd3, 1'b1, 8'h12, 1'b1, 8'h00, 8'hFF, 8'h55, 8'h12, 8'd8},  // R8 boot vector
        '{4'd5, 1'b0, 8'h00, 1'b1, 8'h00, 8'hFF, 8'h55, 8'h12, 8'd3},  // R3 block erase open
        '{4'd4, 1'b0, 8'hFF, 1'b0, 8'h50, 8'hFF, 8'h55, 8'h12, 8'd2},  // R2 same level
        '{4'd4, 1'b0, 8'h33, 1'b0, 8'h50, 8'hFF, 8'h55, 8'h12, 8'd2},  // R2 bad encoding
        '{4'd9, 1'b0, 8'h00, 1'b0, 8'h50, 8'hFF, 8'h55, 8'h12, 8'd9},  // R9 unknown
        '{4'd4, 1'b0, 8'hFE, 1'b1, 8'h00, 8'hFE, 8'h55, 8'h12, 8'd2},  // R2 raise to FE
        '{4'd0, 1'b0, 8'h00, 1'b1, 8'h00, 8'hFE, 8'h55, 8'h12, 8'd4},  // R4 mem read
        '{4'd2, 1'b0, 8'h00, 1'b1, 8'h00, 8'hFE, 8'h55, 8'h12, 8'd4},  // R4 cfg read
        '{4'd1, 1'b0, 8'h00, 1'b0, 8'h50, 8'hFE, 8'h55, 8'h12, 8'd4},  // R4 mem write
        '{4'd3, 1'b0, 8'hAA, 1'b0, 8'h50, 8'hFE, 8'h55, 8'h12, 8'd4},  // R4 cfg write held
        '{4'd5, 1'b0, 8'h00, 1'b0, 8'h50, 8'hFE, 8'h55, 8'h12, 8'd4},  // R4 block erase
        '{4'd8, 1'b0, 8'h00, 1'b1, 8'h00, 8'hFE, 8'h55, 8'h12, 8'd6},  // R6 id read
        '{4'd7, 1'b0, 8'h00, 1'b1, 8'h00, 8'hFE, 8'h55, 8'h12, 8'd6},  // R6 blank check
        '{4'd4, 1'b0, 8'hFE, 1'b0, 8'h50, 8'hFE, 8'h55, 8'h12, 8'd2},  // R2 no repeat
        '{4'd4, 1'b0, 8'hFC, 1'b1, 8'h00, 8'hFC, 8'h55, 8'h12, 8'd2},  // R2 raise to FC
        '{4'd0, 1'b0, 8'h00, 1'b0, 8'h4C, 8'hFC, 8'h55, 8'h12, 8'd5},  // R5 mem read
        '{4'd2, 1'b0, 8'h00, 1'b0, 8'h4C, 8'hFC, 8'h55, 8'h12, 8'd5},  // R5 cfg read
        '{4'd1, 1'b0, 8'h00, 1'b0, 8'h50, 8'hFC, 8'h55, 8'h12, 8'd5},  // R5 mem write
        '{4'd3, 1'b1, 8'h00, 1'b0, 8'h50, 8'hFC, 8'h55, 8'h12, 8'd5},  // R5 cfg write held
        '{4'd5, 1'b0, 8'h00, 1'b0, 8'h50, 8'hFC, 8'h55, 8'h12, 8'd5},  // R5 block erase
        '{4'd4, 1'b0, 8'hFC, 1'b0, 8'h50, 8'hFC, 8'h55, 8'h12, 8'd2},  // R2 top level
        '{4'd8, 1'b0, 8'h00, 1'b1, 8'h00, 8'hFC, 8'h55, 8'h12, 8'd6},  // R6 id read
        '{4'd7, 1'b0, 8'h00, 1'b1, 8'h00, 8'hFC, 8'h55, 8'h12, 8'd6},  // R6 blank check
        '{4'd15,1'b0, 8'h00, 1'b0, 8'h50, 8'hFC, 8'h55, 8'h12, 8'd9},  // R9 unknown
        '{4'd6, 1'b0, 8'h00, 1'b1, 8'h00, 8'hFF, 8'hFF, 8'hFC, 8'd7},  // R7 full erase
        '{4'd0, 1'b0, 8'h00, 1'b1, 8'h00, 8'hFF, 8'hFF, 8'hFC, 8'd3}   // R3 read after erase
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_regs(input string tag, input logic [7:0] l, input logic [7:0] b,
                              input logic [7:0] v);
        check({tag, " level"}, {24'd0, sec_level}, {24'd0, l});
        check({tag, " bstat"}, {24'd0, boot_status}, {24'd0, b});
        check({tag, " bvec"},  {24'd0, boot_vector}, {24'd0, v});
    endtask

    // drive at falling edge, sample answer 1 ns later, sample registers 1 ns after rising edge
    task automatic apply(input logic [3:0] op, input logic sel, input logic [7:0] d,
                         input logic eg, input logic [7:0] ec, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_sel = sel; req_data = d;
        #1;
        check({tag, " grant"}, {31'd0, rsp_grant}, {31'd0, eg});
        check({tag, " deny"},  {31'd0, rsp_deny},  {31'd0, !eg});
        check({tag, " code"},  {24'd0, rsp_code},  {24'd0, ec});
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        // R1 reset values
        check_regs("R1 reset", 8'hFF, 8'hFF, 8'hFC);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1 idle answer
        check("R1 idle grant", {31'd0, rsp_grant}, 32'd0);
        check("R1 idle deny",  {31'd0, rsp_deny},  32'd0);
        check("R1 idle code",  {24'd0, rsp_code},  32'd0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[i].rq, i);
            apply(VEC[i].op, VEC[i].sel, VEC[i].data, VEC[i].eg, VEC[i].ecode, tag);
            check_regs(tag, VEC[i].elvl, VEC[i].ebsb, VEC[i].esbv);
        end

        // R2 direct jump FF to FC, then FE refused as lower
        apply(4'd4, 1'b0, 8'hFC, 1'b1, 8'h00, "R2 jump");
        check_regs("R2 jump", 8'hFC, 8'hFF, 8'hFC);
        apply(4'd4, 1'b0, 8'hFE, 1'b0, 8'h50, "R2 lower");
        check_regs("R2 lower", 8'hFC, 8'hFF, 8'hFC);
        // R9 unknown op with write-looking data leaves state
        apply(4'd12, 1'b1, 8'h00, 1'b0, 8'h50, "R9 op12");
        check_regs("R9 op12", 8'hFC, 8'hFF, 8'hFC);

        // R1 reset returns locked level to open
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        check_regs("R1 rereset", 8'hFF, 8'hFF, 8'hFC);
        @(negedge clk); rst = 1'b0;

        // R7 full erase from open after config change
        apply(4'd3, 1'b1, 8'h3F, 1'b1, 8'h00, "R8 vec pre");
        check_regs("R8 vec pre", 8'hFF, 8'hFF, 8'h3F);
        apply(4'd6, 1'b0, 8'h00, 1'b1, 8'h00, "R7 open erase");
        check_regs("R7 open erase", 8'hFF, 8'hFF, 8'hFC);

        // R10 answer withdrawn when request drops
        @(negedge clk); #1;
        check("R10 drop code", {24'd0, rsp_code}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule